// File: doc/BRIEF.md
# Packed Palette Lookup RAM

This block holds a 256-colour palette for a display pipeline. Storage is organised as 128 words of 32 bits, and each word packs two 16-bit colour entries. A bus side writes whole words and reads them back unchanged. A pixel side presents an 8-bit colour index and, one clock later, receives a 24-bit RGB colour. That colour is unpacked from the stored entry and each 5-bit component is widened to 8 bits.

The block keeps two copies of the data. The first is the raw word image, which serves bus readback and keeps every bit as written, including the per-entry intensity flag. The second is a decoded per-entry colour array that serves the pixel side directly. A bus write updates both copies in the same clock. Both ports are registered. A read or lookup in the same cycle as a write to the same word sees the contents from before that write.

Top module: `palette_lut`

## Requirements
- R1: After reset every word and every entry reads as zero, and `bus_rvalid`, `pix_valid`, `bus_rdata` and `pix_rgb` are all zero.
- R2: The bus selects word n with byte offset 4n inside the 512-byte palette window, so word n = `bus_off[8:2]`. Bits `bus_off[1:0]` are ignored for both reads and writes.
- R3: A bus read returns the raw word exactly as last written, intensity bits included. `bus_rvalid` and `bus_rdata` appear in the cycle after `bus_rd_en`, and `bus_rvalid` is low in the cycle after a cycle with no read.
- R4: Bits 15:0 of word n hold entry 2n, and bits 31:16 hold entry 2n+1.
- R5: Inside a 16-bit entry, red is in bits 4:0, green in bits 9:5 and blue in bits 14:10. The output places red in `pix_rgb[23:16]`, green in `pix_rgb[15:8]` and blue in `pix_rgb[7:0]`.
- R6: Each output component is the 5-bit field shifted left by 3. The three low bits of every output byte are zero.
- R7: Bit 15 of an entry (the intensity flag) has no effect on the looked-up colour.
- R8: `pix_valid` and `pix_rgb` appear in the cycle after `pix_req`. `pix_valid` is low after a cycle with no request, and `pix_rgb` holds its value.
- R9: A lookup in the same cycle as a write to the word holding that entry returns the old colour. A lookup in the following cycle returns the new colour.
- R10: A bus read in the same cycle as a write to the same word returns the old word. A read in the following cycle returns the new word.
- R11: A bus read and a pixel lookup in the same cycle are served independently and both return correct data. `bus_rdata` holds its value when no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write the word at `bus_off` |
| bus_rd_en | input | 1 | Read the word at `bus_off` |
| bus_off | input | 9 | Byte offset inside the palette window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| pix_req | input | 1 | Lookup request |
| pix_idx | input | 8 | Palette entry index |
| pix_rgb | output | 24 | Looked-up colour {red, green, blue} |
| pix_valid | output | 1 | Colour valid |

## Verification
A bus write can land in the same cycle as a pixel lookup or a bus read of the same word, and that collision is where the ordering of the two storage copies matters. The bench provokes it by asserting a write together with a lookup of both entries of that word, and separately together with a read at the same offset. It judges the results against a reference image that is updated only after the cycle's expectations have been queued. The same entries are then looked up again to confirm that the new colour arrives one cycle later.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned PAL_WORDS   = 128;
  localparam int unsigned PAL_WORD_W  = 32;
  localparam int unsigned PAL_ENTRY_W = 16;
  localparam int unsigned PAL_COMP_W  = 5;
  localparam int unsigned PAL_OUT_W   = 8;
  localparam int unsigned PAL_NCOMP   = 3;

  // Component order inside a packed entry, least significant field first.
  typedef enum int unsigned {
    COMP_RED = 0,
    COMP_GRN = 1,
    COMP_BLU = 2
  } pal_comp_e;
endpackage

// File: rtl/pal_rst_sync.sv
module pal_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/pal_raw_store.sv
module pal_raw_store #(
  parameter int unsigned WORDS  = 128,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [WORD_W-1:0] word_q [WORDS];
  logic [WORD_W-1:0] rd_data_d, rd_data_q;
  logic              rd_valid_q;

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
    logic              we;
    logic [WORD_W-1:0] q;
    assign we = wr_en && (idx == IDX_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wr_data;
    end
    assign word_q[gi] = q;
  end

  // Read sees the pre-write contents because the word registers update
  // at the same edge that captures the read data.
  always_comb begin
    rd_data_d = rd_data_q;
    if (rd_en) rd_data_d = word_q[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_data_q  <= rd_data_d;
      rd_valid_q <= rd_en;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;
endmodule

// File: rtl/pal_entry_store.sv
module pal_entry_store #(
  parameter int unsigned WORDS   = 128,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned ENTRY_W = 16,
  parameter int unsigned COL_W   = 15,
  localparam int unsigned PER_WORD = WORD_W / ENTRY_W,
  localparam int unsigned ENTRIES  = WORDS * PER_WORD,
  localparam int unsigned IDX_W    = $clog2(WORDS),
  localparam int unsigned PIX_W    = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              look_en,
  input  logic [PIX_W-1:0]  look_idx,
  output logic [COL_W-1:0]  look_col,
  output logic              look_valid
);
  logic [COL_W-1:0] ent_q [ENTRIES];
  logic [COL_W-1:0] slot_col [PER_WORD];
  logic [PER_WORD*(ENTRY_W-COL_W)-1:0] unused_flag_bits;
  logic [COL_W-1:0] col_d, col_q;
  logic             valid_q;

  // Split the written word into its entries; the bits above the colour
  // fields (intensity) are not kept in the decoded copy.
  for (genvar gs = 0; gs < PER_WORD; gs++) begin : g_slot
    assign slot_col[gs] = wr_data[gs*ENTRY_W +: COL_W];
    assign unused_flag_bits[gs*(ENTRY_W-COL_W) +: (ENTRY_W-COL_W)] =
      wr_data[gs*ENTRY_W+COL_W +: (ENTRY_W-COL_W)];
  end

  for (genvar ge = 0; ge < ENTRIES; ge++) begin : g_ent
    logic             we;
    logic [COL_W-1:0] q;
    assign we = wr_en && (wr_idx == IDX_W'(ge / PER_WORD));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= slot_col[ge % PER_WORD];
    end
    assign ent_q[ge] = q;
  end

  always_comb begin
    col_d = col_q;
    if (look_en) col_d = ent_q[look_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      col_q   <= col_d;
      valid_q <= look_en;
    end
  end

  assign look_col   = col_q;
  assign look_valid = valid_q;
endmodule

// File: rtl/pal_widen.sv
module pal_widen
  import pal_pkg::*;
#(
  parameter int unsigned IN_W  = 5,
  parameter int unsigned OUT_W = 8,
  parameter int unsigned NCOMP = 3
) (
  input  logic [NCOMP*IN_W-1:0]  col,
  output logic [NCOMP*OUT_W-1:0] rgb
);
  localparam int unsigned PAD_W = OUT_W - IN_W;

  // Field k of the entry lands in output byte (NCOMP-1-k): red on top.
  for (genvar gk = 0; gk < NCOMP; gk++) begin : g_comp
    assign rgb[(NCOMP-1-gk)*OUT_W +: OUT_W] = {col[gk*IN_W +: IN_W], {PAD_W{1'b0}}};
  end

  if (NCOMP != PAL_NCOMP || int'(COMP_BLU) != NCOMP - 1) begin : g_bad_ncomp
    initial $error("pal_widen: component count mismatch");
  end
endmodule

// File: rtl/palette_lut.sv
module palette_lut
  import pal_pkg::*;
#(
  parameter int unsigned WORDS   = PAL_WORDS,
  parameter int unsigned WORD_W  = PAL_WORD_W,
  parameter int unsigned ENTRY_W = PAL_ENTRY_W,
  parameter int unsigned COMP_W  = PAL_COMP_W,
  parameter int unsigned OUT_W   = PAL_OUT_W,
  localparam int unsigned IDX_W   = $clog2(WORDS),
  localparam int unsigned OFF_W   = IDX_W + 2,
  localparam int unsigned ENTRIES = WORDS * (WORD_W / ENTRY_W),
  localparam int unsigned PIX_W   = $clog2(ENTRIES),
  localparam int unsigned COL_W   = PAL_NCOMP * COMP_W,
  localparam int unsigned RGB_W   = PAL_NCOMP * OUT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [OFF_W-1:0]  bus_off,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              pix_req,
  input  logic [PIX_W-1:0]  pix_idx,
  output logic [RGB_W-1:0]  pix_rgb,
  output logic              pix_valid
);
  logic             rst_sync_n;
  logic [IDX_W-1:0] word_idx;
  logic [1:0]       unused_byte_sel;
  logic [COL_W-1:0] look_col;

  assign word_idx        = bus_off[OFF_W-1:2];
  assign unused_byte_sel = bus_off[1:0];

  pal_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pal_raw_store #(
    .WORDS  (WORDS),
    .WORD_W (WORD_W)
  ) u_raw (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (bus_wr_en),
    .rd_en    (bus_rd_en),
    .idx      (word_idx),
    .wr_data  (bus_wdata),
    .rd_data  (bus_rdata),
    .rd_valid (bus_rvalid)
  );

  pal_entry_store #(
    .WORDS   (WORDS),
    .WORD_W  (WORD_W),
    .ENTRY_W (ENTRY_W),
    .COL_W   (COL_W)
  ) u_ent (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (bus_wr_en),
    .wr_idx     (word_idx),
    .wr_data    (bus_wdata),
    .look_en    (pix_req),
    .look_idx   (pix_idx),
    .look_col   (look_col),
    .look_valid (pix_valid)
  );

  pal_widen #(
    .IN_W  (COMP_W),
    .OUT_W (OUT_W),
    .NCOMP (PAL_NCOMP)
  ) u_widen (
    .col (look_col),
    .rgb (pix_rgb)
  );
endmodule

// File: rtl/palette_lut_chk.sv
module palette_lut_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned COMP_W = 5,
  parameter int unsigned OUT_W  = 8,
  parameter int unsigned NCOMP  = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_rd_en,
  input logic [WORD_W-1:0]      bus_rdata,
  input logic                   bus_rvalid,
  input logic                   pix_req,
  input logic [NCOMP*OUT_W-1:0] pix_rgb,
  input logic                   pix_valid
);
  localparam int unsigned PAD_W = OUT_W - COMP_W;
  logic [NCOMP-1:0] pad_clear;

  for (genvar gk = 0; gk < NCOMP; gk++) begin : g_pad
    assign pad_clear[gk] = (pix_rgb[gk*OUT_W +: PAD_W] == '0);
  end

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_en |=> bus_rvalid); // R3
  AST_RVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> !bus_rvalid); // R3
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> $stable(bus_rdata)); // R11
  AST_PIX_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    pix_req |=> pix_valid); // R8
  AST_PIX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_req |=> !pix_valid); // R8
  AST_RGB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_req |=> $stable(pix_rgb)); // R8
  AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> (&pad_clear)); // R6
endmodule

bind palette_lut palette_lut_chk #(
  .WORD_W (WORD_W),
  .COMP_W (COMP_W),
  .OUT_W  (OUT_W),
  .NCOMP  (pal_pkg::PAL_NCOMP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_rd_en  (bus_rd_en),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .pix_req    (pix_req),
  .pix_rgb    (pix_rgb),
  .pix_valid  (pix_valid)
);

// File: tb/palette_lut_bench.sv
`timescale 1ns/1ps
module palette_lut_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr_en, bus_rd_en, pix_req;
  logic [8:0]  bus_off;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_rvalid, pix_valid;
  logic [7:0]  pix_idx;
  logic [23:0] pix_rgb;

  always #10 clk = ~clk;

  palette_lut u_palette_lut (
    .clk(clk), .rst_n(rst_n),
    .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_off(bus_off),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pix_req(pix_req), .pix_idx(pix_idx), .pix_rgb(pix_rgb), .pix_valid(pix_valid)
  );

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t        rgb_q[$];
  exp_t        rd_q[$];
  logic [31:0] model [128];
  int          n_run = 0;
  int          n_fail = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected colour from the requirements: entry select R4, fields R5, shift R6.
  function automatic logic [23:0] exp_rgb(input logic [7:0] idx);
    logic [31:0] w;
    logic [15:0] e;
    w = model[idx[7:1]];
    e = idx[0] ? w[31:16] : w[15:0];
    return {e[4:0], 3'b000, e[9:5], 3'b000, e[14:10], 3'b000};
  endfunction

  // One bus/pixel cycle; expectations use the image before this cycle's write.
  task automatic cyc(input logic we, input logic rd, input logic [8:0] off,
                     input logic [31:0] wd, input logic pv, input logic [7:0] idx,
                     input string tag);
    exp_t item;
    @(negedge clk);
    bus_wr_en = we; bus_rd_en = rd; bus_off = off; bus_wdata = wd;
    pix_req = pv; pix_idx = idx;
    if (rd) begin item.val = model[off[8:2]]; item.tag = tag; rd_q.push_back(item); end
    if (pv) begin item.val = {8'h00, exp_rgb(idx)}; item.tag = tag; rgb_q.push_back(item); end
    if (we) model[off[8:2]] = wd;
  endtask

  task automatic look_lit(input logic [7:0] idx, input logic [23:0] exp, input string tag);
    exp_t item;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_rd_en = 1'b0; pix_req = 1'b1; pix_idx = idx;
    item.val = {8'h00, exp}; item.tag = tag; rgb_q.push_back(item);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_wr_en = 1'b0; bus_rd_en = 1'b0; pix_req = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h9E37_79B9) ^ 32'h5A5A_A5A5;
  endfunction

  // Monitor: pop and compare as results appear.
  always @(negedge clk) begin
    if (rst_n) begin
      if (pix_valid) begin
        if (rgb_q.size() == 0) check("R8 unexpected pix_valid", 32'd1, 32'd0);
        else begin exp_t h; h = rgb_q.pop_front(); check(h.tag, {8'h00, pix_rgb}, h.val); end
      end
      if (bus_rvalid) begin
        if (rd_q.size() == 0) check("R3 unexpected bus_rvalid", 32'd1, 32'd0);
        else begin exp_t h; h = rd_q.pop_front(); check(h.tag, bus_rdata, h.val); end
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [23:0] held_rgb;
    logic [31:0] held_rd;
    for (int i = 0; i < 128; i++) model[i] = '0;
    rst_n = 1'b0; bus_wr_en = 0; bus_rd_en = 0; pix_req = 0;
    bus_off = '0; bus_wdata = '0; pix_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state at the ports, then zero contents.
    check("R1 rvalid after reset", {31'd0, bus_rvalid}, 32'd0);
    check("R1 pix_valid after reset", {31'd0, pix_valid}, 32'd0);
    check("R1 rdata after reset", bus_rdata, 32'd0);
    check("R1 rgb after reset", {8'h00, pix_rgb}, 32'd0);
    cyc(0, 1, 9'h000, '0, 1, 8'd0,   "R1 word0/entry0 zero");
    cyc(0, 1, 9'h1FC, '0, 1, 8'd255, "R1 word127/entry255 zero");

    // R5 R6 R7: literal colours, intensity bit set on the upper entry.
    cyc(1, 0, 9'h00C, 32'h801F_7C00, 0, 8'd0, "R4 write word3");
    look_lit(8'd6, 24'h0000F8, "R5 blue field of entry 6");
    look_lit(8'd7, 24'hF80000, "R7 red entry with intensity set");
    cyc(1, 0, 9'h010, 32'h0000_03E0, 0, 8'd0, "R5 write word4");
    look_lit(8'd8, 24'h00F800, "R5 green field of entry 8");
    cyc(1, 0, 9'h014, 32'hFFFF_7FFF, 0, 8'd0, "R7 write word5");
    look_lit(8'd10, 24'hF8F8F8, "R7 entry 10 no intensity");
    look_lit(8'd11, 24'hF8F8F8, "R7 entry 11 intensity ignored");
    cyc(1, 0, 9'h018, 32'h2109_8421, 0, 8'd0, "R6 write word6");
    look_lit(8'd12, 24'h080808, "R6 lsb of each field");
    cyc(0, 1, 9'h00C, '0, 0, 8'd0, "R3 raw readback keeps intensity");
    cyc(0, 1, 9'h014, '0, 0, 8'd0, "R3 raw readback all ones high");

    // R2: byte-select bits ignored on write and read.
    cyc(1, 0, 9'h005, 32'hDEAD_BEEF, 0, 8'd0, "R2 write off 0x005");
    cyc(0, 1, 9'h006, '0, 1, 8'd3, "R2 read off 0x006 word1");
    cyc(0, 1, 9'h007, '0, 1, 8'd2, "R2 read off 0x007 word1");

    // R9 R10: write collides with read and lookups of the same word.
    cyc(1, 1, 9'h020, 32'h1234_5678, 1, 8'd16, "R9 R10 collide old");
    cyc(0, 1, 9'h020, '0, 1, 8'd17, "R9 R10 next cycle new");
    cyc(1, 1, 9'h020, 32'hABCD_0F0F, 1, 8'd17, "R9 R10 second collide old");
    cyc(0, 1, 9'h020, '0, 1, 8'd16, "R9 R10 second new");
    idle();

    // R4 R11: fill every word, then sweep all entries with reads alongside.
    for (int i = 0; i < 128; i++) cyc(1, 0, 9'(i * 4), pat(i), 0, 8'd0, "R4 fill");
    for (int i = 0; i < 256; i++)
      cyc(0, 1, 9'((i % 128) * 4), '0, 1, 8'(i), "R11 sweep read+lookup");
    for (int i = 0; i < 128; i++)
      cyc(1, 0, 9'(i * 4), ~pat(i), 1, 8'(255 - 2 * i), "R9 fill over lookups");
    cyc(0, 1, 9'h1FC, '0, 1, 8'd254, "R4 top word low entry");
    cyc(0, 0, 9'h000, '0, 1, 8'd255, "R4 top word high entry");
    idle();

    // R8 R11: outputs hold while idle.
    @(negedge clk);
    held_rgb = pix_rgb; held_rd = bus_rdata;
    repeat (3) idle();
    @(negedge clk);
    check("R8 rgb held while idle", {8'h00, pix_rgb}, {8'h00, held_rgb});
    check("R11 rdata held while idle", bus_rdata, held_rd);
    check("R8 no pending lookups", 32'(rgb_q.size()), 32'd0);
    check("R3 no pending reads", 32'(rd_q.size()), 32'd0);
    finish_run();
  end
endmodule